// File: doc/BRIEF.md
# Multi-line exclusive grant arbiter

This block sits on the system side and gives a requesting core exclusive ownership of a group of cache lines as a single unit. A request names the core and lists up to `LINES` line addresses. A per-slot mask marks which address slots are present. The arbiter looks up the addresses in an associative line table in which each entry is tagged with its owner core. If every line is free and space is available, all of the lines are entered in the same cycle. If not, the request waits in a FIFO queue, and the response reports how many contending requests stand ahead of it.

A release names the core and carries the same address list that the request carried. Every matching entry owned by that core is removed in one cycle. The arbiter then walks the waiting queue from oldest to newest. It grants, in order, each waiting request whose lines are all free and that fits in the table. Each of these grants produces its own response.

Top module: `group_lock_arbiter`

## Requirements
- R1: After reset the table and the queue are empty, no response is pending, and both ready outputs are high.
- R2: An accepted request is granted when none of its lines is held, the table has space, and no queued request shares a line with it. The arbiter returns `rsp_grant_o`=1 and `rsp_ahead_o`=0 on the cycle after the handshake. Every grant response carries ahead=0.
- R3: Bit i of the request mask selects the address at bits [i*ADDR_W +: ADDR_W]. Either all selected lines enter the table in one cycle or none of them do. A request that does not fully fit takes no entries.
- R4: A request that cannot be granted is queued and answered with grant=0. Its ahead count is the number of distinct cores holding any of its lines plus the number of queued requests sharing a line with it.
- R5: A request that shares a line only with a queued request is queued, even when all of its lines are free.
- R6: A release removes, in one cycle, every entry that matches one of the listed addresses and is owned by the releasing core. A later request for those lines can then be granted.
- R7: After a release that removed at least one entry, the queued requests are examined oldest first. Each one whose lines are free and that fits is granted in that order, one per cycle. Blocked requests keep their place in the queue.
- R8: When the table lacks room for all of a request's lines, the request waits, with ahead counting only the overlaps. It is granted after a release frees enough room.
- R9: A release that matches no entry owned by the releasing core changes nothing: no entry is removed, no response is produced, and no queue scan starts.
- R10: While the queue scan runs, both ready outputs are low. While the queue is full, `req_ready_o` is low.
- R11: A transfer takes place on a clock edge where valid and ready are both high. When a release and a request are both valid, the release goes first and `req_ready_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_core_i | input | CORE_W | Requesting core |
| req_mask_i | input | LINES | Present address slots |
| req_addr_i | input | LINES*ADDR_W | Line addresses, slot i at [i*ADDR_W +: ADDR_W] |
| rel_valid_i | input | 1 | Release valid |
| rel_ready_o | output | 1 | Release accepted when high with valid |
| rel_core_i | input | CORE_W | Releasing core |
| rel_mask_i | input | LINES | Present address slots of the release |
| rel_addr_i | input | LINES*ADDR_W | Line addresses to release |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_core_o | output | CORE_W | Core the response is for |
| rsp_grant_o | output | 1 | 1 granted, 0 queued |
| rsp_ahead_o | output | CNT_W | Contending requests ahead of this one |

## Verification
The assertions rely on several properties of the inputs. Each core has at most one group outstanding, whether held or queued. The addresses within one request are distinct. A core never asks again for lines it already holds. The stimulus keeps to all of these: every core ID has at most one live group, and each group uses consecutive distinct addresses from a base. Releases reuse the same base and mask as the matching request, except where a release is meant to be ignored.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} arb_state_e;
endpackage

// File: rtl/line_grant_table.sv
module line_grant_table #(
  parameter int NCORE   = 8,
  parameter int CORE_W  = 3,
  parameter int ADDR_W  = 16,
  parameter int LINES   = 8,
  parameter int ENTRIES = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CORE_W-1:0]       cand_core_i,
  input  logic [LINES-1:0]        cand_mask_i,
  input  logic [LINES*ADDR_W-1:0] cand_addr_i,
  input  logic                    alloc_i,
  input  logic                    rel_i,
  input  logic [CORE_W-1:0]       rel_core_i,
  input  logic [LINES-1:0]        rel_mask_i,
  input  logic [LINES*ADDR_W-1:0] rel_addr_i,
  output logic                    conflict_o,
  output logic [NCORE-1:0]        holders_o,
  output logic                    fits_o,
  output logic                    rel_hit_o
);
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1;

  logic [ENTRIES-1:0] v_q, take, drop;
  logic [CORE_W-1:0]  own_q [ENTRIES];
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [LW-1:0]      pick  [ENTRIES];
  logic [LINES-1:0]   placed;

  // lookup of candidate and release lists
  always_comb begin
    conflict_o = 1'b0;
    holders_o  = '0;
    drop       = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      for (int l = 0; l < LINES; l++) begin
        if (v_q[e] && cand_mask_i[l] && tag_q[e] == cand_addr_i[l*ADDR_W +: ADDR_W]) begin
          conflict_o          = 1'b1;
          holders_o[own_q[e]] = 1'b1;
        end
        if (v_q[e] && own_q[e] == rel_core_i && rel_mask_i[l] &&
            tag_q[e] == rel_addr_i[l*ADDR_W +: ADDR_W])
          drop[e] = 1'b1;
      end
    end
  end

  assign rel_hit_o = |drop;

  // place each present line into its own free slot
  always_comb begin
    take   = '0;
    placed = '0;
    for (int e = 0; e < ENTRIES; e++) pick[e] = '0;
    for (int l = 0; l < LINES; l++) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (cand_mask_i[l] && !placed[l] && !v_q[e] && !take[e]) begin
          take[e]   = 1'b1;
          placed[l] = 1'b1;
          pick[e]   = LW'(l);
        end
      end
    end
  end

  assign fits_o = &(placed | ~cand_mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        own_q[e] <= '0;
        tag_q[e] <= '0;
      end
    end else if (rel_i) begin
      v_q <= v_q & ~drop;
    end else if (alloc_i) begin
      v_q <= v_q | take;
      for (int e = 0; e < ENTRIES; e++) begin
        if (take[e]) begin
          own_q[e] <= cand_core_i;
          tag_q[e] <= cand_addr_i[pick[e]*ADDR_W +: ADDR_W];
        end
      end
    end
  end

  AST_ALLOC_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> fits_o && !conflict_o); // R2
  AST_GROUP_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> $countones(v_q) == $past($countones(v_q)) + $past($countones(cand_mask_i))); // R3
  AST_REL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && !rel_hit_o |=> $stable(v_q)); // R9
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_i && rel_i)); // R11
endmodule

// File: rtl/grant_wait_queue.sv
module grant_wait_queue #(
  parameter int CORE_W = 3,
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  parameter int DEPTH  = 4,
  localparam int QCW   = $clog2(DEPTH + 1),
  localparam int QIW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic                    pop_i,
  input  logic [QIW-1:0]          sel_idx_i,
  input  logic [CORE_W-1:0]       in_core_i,
  input  logic [LINES-1:0]        in_mask_i,
  input  logic [LINES*ADDR_W-1:0] in_addr_i,
  output logic [QCW-1:0]          ovl_cnt_o,
  output logic [CORE_W-1:0]       sel_core_o,
  output logic [LINES-1:0]        sel_mask_o,
  output logic [LINES*ADDR_W-1:0] sel_addr_o,
  output logic [QCW-1:0]          count_o,
  output logic                    full_o
);
  logic [CORE_W-1:0]       q_core [DEPTH];
  logic [LINES-1:0]        q_mask [DEPTH];
  logic [LINES*ADDR_W-1:0] q_addr [DEPTH];
  logic [QCW-1:0]          cnt_q;
  logic [DEPTH-1:0]        hit;

  always_comb begin
    hit = '0;
    for (int i = 0; i < DEPTH; i++)
      for (int a = 0; a < LINES; a++)
        for (int b = 0; b < LINES; b++)
          if (i < int'(cnt_q) && q_mask[i][a] && in_mask_i[b] &&
              q_addr[i][a*ADDR_W +: ADDR_W] == in_addr_i[b*ADDR_W +: ADDR_W])
            hit[i] = 1'b1;
  end

  assign ovl_cnt_o  = QCW'($countones(hit));
  assign sel_core_o = q_core[sel_idx_i];
  assign sel_mask_o = q_mask[sel_idx_i];
  assign sel_addr_o = q_addr[sel_idx_i];
  assign count_o    = cnt_q;
  assign full_o     = (int'(cnt_q) == DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_core[i] <= '0;
        q_mask[i] <= '0;
        q_addr[i] <= '0;
      end
    end else if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel_idx_i)) begin
          q_core[i] <= q_core[i+1];
          q_mask[i] <= q_mask[i+1];
          q_addr[i] <= q_addr[i+1];
        end
      end
      cnt_q <= cnt_q - 1'b1;
    end else if (push_i) begin
      q_core[cnt_q[QIW-1:0]] <= in_core_i;
      q_mask[cnt_q[QIW-1:0]] <= in_mask_i;
      q_addr[cnt_q[QIW-1:0]] <= in_addr_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_Q_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R10
  AST_Q_POP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> int'(sel_idx_i) < int'(cnt_q)); // R7
  AST_Q_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i)); // R11
endmodule

// File: rtl/group_lock_arbiter.sv
module group_lock_arbiter
  import grp_arb_pkg::*;
#(
  parameter int NCORE   = 8,
  parameter int ADDR_W  = 16,
  parameter int LINES   = 8,
  parameter int ENTRIES = 32,
  parameter int QDEPTH  = 4,
  localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int CNT_W  = $clog2(NCORE + QDEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [CORE_W-1:0]       req_core_i,
  input  logic [LINES-1:0]        req_mask_i,
  input  logic [LINES*ADDR_W-1:0] req_addr_i,
  input  logic                    rel_valid_i,
  output logic                    rel_ready_o,
  input  logic [CORE_W-1:0]       rel_core_i,
  input  logic [LINES-1:0]        rel_mask_i,
  input  logic [LINES*ADDR_W-1:0] rel_addr_i,
  output logic                    rsp_valid_o,
  output logic [CORE_W-1:0]       rsp_core_o,
  output logic                    rsp_grant_o,
  output logic [CNT_W-1:0]        rsp_ahead_o
);
  localparam int QCW = $clog2(QDEPTH + 1);
  localparam int QIW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  arb_state_e              state_q;
  logic [QIW-1:0]          ptr_q;
  logic                    scan, ok, conflict, fits, rel_hit, q_full, scan_last;
  logic                    rel_fire, req_fire, req_grant, req_wait, scan_grant;
  logic [NCORE-1:0]        holders;
  logic [QCW-1:0]          q_ovl, q_cnt;
  logic [CORE_W-1:0]       sel_core, cand_core;
  logic [LINES-1:0]        sel_mask, cand_mask;
  logic [LINES*ADDR_W-1:0] sel_addr, cand_addr;
  logic [CNT_W-1:0]        ahead;

  assign scan        = (state_q == ST_SCAN);
  assign cand_core   = scan ? sel_core : req_core_i;
  assign cand_mask   = scan ? sel_mask : req_mask_i;
  assign cand_addr   = scan ? sel_addr : req_addr_i;
  assign rel_ready_o = !scan;
  assign req_ready_o = !scan && !rel_valid_i && !q_full;
  assign rel_fire    = rel_valid_i && rel_ready_o;
  assign req_fire    = req_valid_i && req_ready_o;
  assign ok          = fits && !conflict;
  assign req_grant   = req_fire && ok && (q_ovl == '0);
  assign req_wait    = req_fire && !req_grant;
  assign scan_grant  = scan && ok;
  assign scan_last   = (QCW'(ptr_q) == q_cnt - 1'b1);
  assign ahead       = CNT_W'($countones(holders)) + CNT_W'(q_ovl);

  line_grant_table #(
    .NCORE(NCORE), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .LINES(LINES), .ENTRIES(ENTRIES)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_core_i(cand_core),
    .cand_mask_i(cand_mask),
    .cand_addr_i(cand_addr),
    .alloc_i    (req_grant || scan_grant),
    .rel_i      (rel_fire),
    .rel_core_i (rel_core_i),
    .rel_mask_i (rel_mask_i),
    .rel_addr_i (rel_addr_i),
    .conflict_o (conflict),
    .holders_o  (holders),
    .fits_o     (fits),
    .rel_hit_o  (rel_hit)
  );

  grant_wait_queue #(
    .CORE_W(CORE_W), .ADDR_W(ADDR_W), .LINES(LINES), .DEPTH(QDEPTH)
  ) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (req_wait),
    .pop_i     (scan_grant),
    .sel_idx_i (ptr_q),
    .in_core_i (req_core_i),
    .in_mask_i (req_mask_i),
    .in_addr_i (req_addr_i),
    .ovl_cnt_o (q_ovl),
    .sel_core_o(sel_core),
    .sel_mask_o(sel_mask),
    .sel_addr_o(sel_addr),
    .count_o   (q_cnt),
    .full_o    (q_full)
  );

  // scan walks the queue oldest first; a grant shifts the rest down onto ptr
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
    end else if (!scan) begin
      if (rel_fire && rel_hit && q_cnt != '0) begin
        state_q <= ST_SCAN;
        ptr_q   <= '0;
      end
    end else if (scan_last) begin
      state_q <= ST_IDLE;
    end else if (!ok) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_core_o  <= '0;
      rsp_grant_o <= 1'b0;
      rsp_ahead_o <= '0;
    end else begin
      rsp_valid_o <= req_fire || scan_grant;
      rsp_core_o  <= scan ? sel_core : req_core_i;
      rsp_grant_o <= req_grant || scan_grant;
      rsp_ahead_o <= req_wait ? ahead : '0;
    end
  end

  AST_GRANT_NO_AHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_grant_o |-> rsp_ahead_o == '0); // R2
  AST_RSP_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_fire |=> rsp_valid_o && rsp_core_o == $past(req_core_i)); // R11
  AST_SCAN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan |-> !req_fire && !rel_fire); // R10
  AST_REL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |-> !req_fire); // R11
endmodule

// File: tb/group_lock_arbiter_tb.sv
`timescale 1ns/1ps
module group_lock_arbiter_tb;
  localparam int LINES = 8;
  localparam int AW    = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, rel_valid = 1'b0;
  logic [2:0]      req_core = '0, rel_core = '0;
  logic [LINES-1:0] req_mask = '0, rel_mask = '0;
  logic [LINES*AW-1:0] req_addr = '0, rel_addr = '0;
  logic            req_ready, rel_ready, rsp_valid, rsp_grant;
  logic [2:0]      rsp_core;
  logic [3:0]      rsp_ahead;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  group_lock_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_core_i(req_core),
    .req_mask_i(req_mask), .req_addr_i(req_addr),
    .rel_valid_i(rel_valid), .rel_ready_o(rel_ready), .rel_core_i(rel_core),
    .rel_mask_i(rel_mask), .rel_addr_i(rel_addr),
    .rsp_valid_o(rsp_valid), .rsp_core_o(rsp_core), .rsp_grant_o(rsp_grant),
    .rsp_ahead_o(rsp_ahead)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_req(int core, int mask, int base);
    @(negedge clk);
    req_core = 3'(core);
    req_mask = LINES'(mask);
    for (int l = 0; l < LINES; l++) req_addr[l*AW +: AW] = AW'(base + l);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic send_rel(int core, int mask, int base);
    @(negedge clk);
    rel_core = 3'(core);
    rel_mask = LINES'(mask);
    for (int l = 0; l < LINES; l++) rel_addr[l*AW +: AW] = AW'(base + l);
    rel_valid = 1'b1;
    while (!rel_ready) @(negedge clk);
    @(posedge clk);
    #1 rel_valid = 1'b0;
  endtask

  task automatic expect_rsp(string tag, int core, int grant, int ahead);
    int n = 0;
    @(negedge clk);
    while (!rsp_valid && n < 30) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) chk({tag, " response present"}, 0, 1);
    else begin
      chk({tag, " core"}, int'(rsp_core), core);
      chk({tag, " grant"}, int'(rsp_grant), grant);
      chk({tag, " ahead"}, int'(rsp_ahead), ahead);
    end
  endtask

  task automatic expect_quiet(string tag, int cycles);
    int seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (rsp_valid) seen++;
    end
    chk({tag, " no response"}, seen, 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rel_ready", int'(rel_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_contention;
    send_req(1, 8'h0F, 'h100);           // 100..103
    expect_rsp("R2 free group", 1, 1, 0);
    send_req(2, 8'h07, 'h103);           // 103..105, one holder
    expect_rsp("R4 one holder", 2, 0, 1);
    send_req(3, 8'h81, 'h100);           // 100,107
    expect_rsp("R4 holder only", 3, 0, 1);
    send_req(4, 8'h05, 'h105);           // 105,107: two queued overlaps
    expect_rsp("R5 queued overlaps", 4, 0, 2);
    send_rel(5, 8'h01, 'h100);           // core 5 holds nothing
    expect_quiet("R9 foreign release", 6);
    send_rel(1, 8'h01, 'h300);           // core 1 holds, address absent
    expect_quiet("R9 unmatched address", 6);
    send_req(6, 8'h01, 'h200);
    expect_rsp("R9 state intact", 6, 1, 0);
    send_rel(1, 8'h0F, 'h100);
    chk("R10 rel_ready during scan", int'(rel_ready), 0);
    chk("R10 req_ready during scan", int'(req_ready), 0);
    expect_rsp("R7 oldest first", 2, 1, 0);
    expect_rsp("R7 second freed", 3, 1, 0);
    expect_quiet("R7 blocked stays", 6);
    send_rel(2, 8'h07, 'h103);
    expect_quiet("R7 still blocked", 6);
    send_rel(3, 8'h81, 'h100);
    expect_rsp("R6 release frees", 4, 1, 0);
    send_rel(4, 8'h05, 'h105);
    send_rel(6, 8'h01, 'h200);
    send_req(7, 8'hFF, 'h100);           // all lines just released
    expect_rsp("R6 lines reusable", 7, 1, 0);
    send_rel(7, 8'hFF, 'h100);
  endtask

  task automatic t_priority;
    @(negedge clk);
    rel_core = 3'd7; rel_mask = 8'h01; rel_addr = '0; rel_addr[AW-1:0] = 16'h900;
    req_core = 3'd6; req_mask = 8'h01; req_addr = '0; req_addr[AW-1:0] = 16'h910;
    rel_valid = 1'b1; req_valid = 1'b1;
    #1;
    chk("R11 req_ready with release", int'(req_ready), 0);
    chk("R11 rel_ready", int'(rel_ready), 1);
    @(posedge clk);
    #1 rel_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    expect_rsp("R11 request after release", 6, 1, 0);
    send_rel(6, 8'h01, 'h910);
  endtask

  task automatic t_queue_full;
    send_req(0, 8'h01, 'h800);
    expect_rsp("R2 holder", 0, 1, 0);
    for (int c = 1; c <= 4; c++) begin
      send_req(c, 8'h01, 'h800);
      expect_rsp("R4 queued depth", c, 0, c);
    end
    @(negedge clk);
    chk("R10 req_ready when full", int'(req_ready), 0);
    for (int c = 0; c < 4; c++) begin
      send_rel(c, 8'h01, 'h800);
      expect_rsp("R7 fifo handoff", c + 1, 1, 0);
    end
    send_rel(4, 8'h01, 'h800);
    @(negedge clk);
    chk("R10 req_ready after drain", int'(req_ready), 1);
  endtask

  task automatic t_capacity;
    for (int c = 0; c < 4; c++) begin
      send_req(c, 8'hFF, 'h400 + 'h10 * c);
      expect_rsp("R3 eight lines", c, 1, 0);
    end
    send_req(4, 8'h01, 'h500);
    expect_rsp("R8 table full waits", 4, 0, 0);
    send_rel(0, 8'hFF, 'h400);
    expect_rsp("R8 granted after room", 4, 1, 0);
    for (int c = 1; c < 5; c++)
      send_rel(c, (c == 4) ? 8'h01 : 8'hFF, (c == 4) ? 'h500 : 'h400 + 'h10 * c);
    // 28 of 32 used: an 8-line group must take nothing
    for (int c = 0; c < 4; c++) begin
      send_req(c, 8'h7F, 'h600 + 'h10 * c);
      expect_rsp("R3 seven lines", c, 1, 0);
    end
    send_req(4, 8'hFF, 'h700);
    expect_rsp("R3 no partial grant", 4, 0, 0);
    send_req(5, 8'h0F, 'h710);
    expect_rsp("R3 four slots untouched", 5, 1, 0);
    send_req(6, 8'h01, 'h720);
    expect_rsp("R8 no room", 6, 0, 0);
    send_rel(0, 8'h7F, 'h600);
    expect_rsp("R7 skip blocked head", 6, 1, 0);
    send_rel(1, 8'h7F, 'h610);
    expect_rsp("R8 large group granted", 4, 1, 0);
    send_rel(2, 8'h7F, 'h620);
    send_rel(3, 8'h7F, 'h630);
    send_rel(4, 8'hFF, 'h700);
    send_rel(5, 8'h0F, 'h710);
    send_rel(6, 8'h01, 'h720);
    send_req(0, 8'hFF, 'h000);
    expect_rsp("R6 table emptied", 0, 1, 0);
    send_rel(0, 8'hFF, 'h000);
  endtask

  initial begin
    t_reset;
    t_contention;
    t_priority;
    t_queue_full;
    t_capacity;
    expect_quiet("R9 idle end", 4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule